// File: doc/BRIEF.md
# Indirect-Access Buffer Transfer Controller

This block is the host-facing side of a sector buffer controller. A host with a narrow bus reaches sixteen internal byte registers through just two locations. One is an index latch. The other is a data window onto whichever register the index selects. After each access through the data window the index steps on by one, so a host can program a run of consecutive registers with back-to-back writes. The index also wraps from the last register back to the first. Index zero is the one exception: it never moves.

Through these registers the host sets three things: a 16-bit buffer start address, a 12-bit byte count holding the length minus one, and two control bits. A write to the start register, whatever the data, launches a transfer. The sequencer then reads the 64 KiB buffer at rising addresses, one byte every seven clock cycles, and presents each byte on a streaming output. When the last byte has gone out, a completion flag sets. That flag drives an interrupt line, which can be masked. A write to the acknowledge register, whatever the data, clears it.

Top module: `bxc_host_xfer`

## Requirements
- R1: After reset, the status register (index 1) reads 0xFF, the count reads 0 at index 2 and index 3, `irq` and `out_valid` are low, the interrupt enable is off and the output-disable bit is set.
- R2: A host write with `host_sel`=0 loads bits [3:0] of `host_wdata` into the register index. A host read with `host_sel`=0 returns the index in bits [3:0], with zeros above.
- R3: Each data access (`host_sel`=1, read or write) steps the index by one in the following cycle, wrapping from 15 to 0. When the index is 0 it stays at 0.
- R4: The 12-bit count is written as its low byte at index 2 and its upper nibble in bits [3:0] at index 3. Index 3 reads back the completion flag in bit 7, zeros in bits 6:4 and the upper nibble in bits 3:0. Count writes made while a transfer is busy are ignored.
- R5: The start address is written as its low byte at index 4 and its high byte at index 5. The transfer reads the buffer from that address upward, wrapping from 0xFFFF to 0x0000.
- R6: A write to index 6, whatever the data, starts a transfer of count+1 bytes. It does so only when the block is idle and control bit 1 (output disable, active low enable) is 0. Otherwise the write is ignored, including while a transfer is busy.
- R7: Buffer reads (`buf_rd_en`) are exactly 7 cycles apart within a transfer. Each streamed byte appears with `out_valid` one cycle after its read and equals the buffer's data for that address.
- R8: The count decrements once per byte read and reads 0xFFF after a transfer completes.
- R9: Status register index 1 reads bit 6 = NOT completion flag and bit 3 = NOT busy. All other bits read 1.
- R10: Completion of a transfer sets the completion flag. `irq` is high exactly when the flag is set and control bit 6 (interrupt enable) is 1. Control bits are written at index 1.
- R11: A write to index 7, whatever the data, clears the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | 0 selects the index latch, 1 the data window |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the same cycle as the strobe |
| buf_rd_en | output | 1 | Buffer read request |
| buf_addr | output | 16 | Buffer read address |
| buf_rdata | input | 8 | Buffer data, one cycle after the request |
| out_valid | output | 1 | Streamed byte valid |
| out_data | output | 8 | Streamed byte |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The transfer path is driven with four setups. A four-byte run from a mid-range address shows byte order, pacing and the final count. A single-byte run with the interrupt masked separates the flag from the interrupt line. A run that crosses 0xFFFF tells a wrapping address counter from a carrying or saturating one. A run with a second start strobe and count writes injected mid-flight tells a sequencer that ignores them from one that restarts or shortens. Index-pointer patterns that sit at index 0, step through consecutive registers and wrap from 15 separate the sticky-zero rule from plain increment. A start issued with the output disabled shows that the gate blocks every buffer read.

// File: rtl/bxc_pkg.sv
`timescale 1ns/1ps
package bxc_pkg;
  localparam int IDX_CTRL    = 1;
  localparam int IDX_CNT_LO  = 2;
  localparam int IDX_CNT_HI  = 3;
  localparam int IDX_ADDR_LO = 4;
  localparam int IDX_ADDR_HI = 5;
  localparam int IDX_START   = 6;
  localparam int IDX_ACK     = 7;

  localparam int CTRL_IRQ_EN_BIT  = 6;
  localparam int CTRL_OUT_OFF_BIT = 1;
  localparam int STAT_FLAG_N_BIT  = 6;
  localparam int STAT_BUSY_N_BIT  = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_FLUSH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bxc_rst_sync.sv
`timescale 1ns/1ps
module bxc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/bxc_index_ptr.sv
`timescale 1ns/1ps
module bxc_index_ptr #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx_q
);
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (load) begin
      idx_d  = load_val;
      idx_en = 1'b1;
    end else if (step && (idx_q != '0)) begin
      idx_d  = idx_q + 1'b1;
      idx_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end
endmodule

// File: rtl/bxc_regs.sv
`timescale 1ns/1ps
module bxc_regs
  import bxc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              cnt_dec,
  input  logic              done,
  output logic              irq_en_q,
  output logic              out_off_q,
  output logic [ADDR_W-1:0] start_addr_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              flag_q,
  output logic              start_pulse,
  output logic              ack_pulse,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HI_W = CNT_W - DATA_W;

  logic wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_addr_lo, wr_addr_hi;
  logic [CNT_W-1:0]  count_d;
  logic              count_en;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;
  logic              flag_d;
  logic [DATA_W-1:0] status_v;
  logic [DATA_W-1:0] cnt_hi_v;

  always_comb begin
    wr_ctrl     = data_wr && (idx == IDX_W'(IDX_CTRL));
    wr_cnt_lo   = data_wr && (idx == IDX_W'(IDX_CNT_LO));
    wr_cnt_hi   = data_wr && (idx == IDX_W'(IDX_CNT_HI));
    wr_addr_lo  = data_wr && (idx == IDX_W'(IDX_ADDR_LO));
    wr_addr_hi  = data_wr && (idx == IDX_W'(IDX_ADDR_HI));
    start_pulse = data_wr && (idx == IDX_W'(IDX_START));
    ack_pulse   = data_wr && (idx == IDX_W'(IDX_ACK));
  end

  always_comb begin
    count_d  = count_q;
    count_en = 1'b0;
    if (cnt_dec) begin
      count_d  = count_q - 1'b1;
      count_en = 1'b1;
    end else if (!busy && wr_cnt_lo) begin
      count_d[DATA_W-1:0] = wdata;
      count_en = 1'b1;
    end else if (!busy && wr_cnt_hi) begin
      count_d[CNT_W-1:DATA_W] = wdata[HI_W-1:0];
      count_en = 1'b1;
    end
  end

  always_comb begin
    addr_d  = start_addr_q;
    addr_en = wr_addr_lo || wr_addr_hi;
    if (wr_addr_lo) addr_d[DATA_W-1:0]      = wdata;
    if (wr_addr_hi) addr_d[ADDR_W-1:DATA_W] = wdata;
  end

  always_comb begin
    flag_d = flag_q;
    if (done)           flag_d = 1'b1;
    else if (ack_pulse) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q  <= 1'b0;
      out_off_q <= 1'b1;
    end else if (wr_ctrl) begin
      irq_en_q  <= wdata[CTRL_IRQ_EN_BIT];
      out_off_q <= wdata[CTRL_OUT_OFF_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       start_addr_q <= '0;
    else if (addr_en) start_addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    status_v                  = '1;
    status_v[STAT_FLAG_N_BIT] = ~flag_q;
    status_v[STAT_BUSY_N_BIT] = ~busy;
    cnt_hi_v                  = '0;
    cnt_hi_v[HI_W-1:0]        = count_q[CNT_W-1:DATA_W];
    cnt_hi_v[DATA_W-1]        = flag_q;
    case (idx)
      IDX_W'(IDX_CTRL):   rd_data = status_v;
      IDX_W'(IDX_CNT_LO): rd_data = count_q[DATA_W-1:0];
      IDX_W'(IDX_CNT_HI): rd_data = cnt_hi_v;
      default:            rd_data = '0;
    endcase
  end
endmodule

// File: rtl/bxc_seq.sv
`timescale 1ns/1ps
module bxc_seq
  import bxc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int PACE   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pulse,
  input  logic              out_en,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  count,
  output logic              busy,
  output logic              buf_rd_en,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              done,
  output logic              out_valid
);
  localparam int PW = (PACE > 1) ? $clog2(PACE) : 1;

  seq_state_e        state_q, state_d;
  logic [PW-1:0]     pace_q, pace_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              outv_q;

  always_comb begin
    state_d   = state_q;
    pace_d    = pace_q;
    addr_d    = addr_q;
    buf_rd_en = (state_q == SEQ_RUN) && (pace_q == '0);
    done      = (state_q == SEQ_FLUSH);
    case (state_q)
      SEQ_IDLE: begin
        if (start_pulse && out_en) begin
          state_d = SEQ_RUN;
          pace_d  = '0;
          addr_d  = start_addr;
        end
      end
      SEQ_RUN: begin
        if (buf_rd_en) begin
          addr_d = addr_q + 1'b1;
          pace_d = PW'(PACE - 1);
          if (count == '0) state_d = SEQ_FLUSH;
        end else begin
          pace_d = pace_q - 1'b1;
        end
      end
      SEQ_FLUSH: state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pace_q  <= '0;
      addr_q  <= '0;
      outv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pace_q  <= pace_d;
      addr_q  <= addr_d;
      outv_q  <= buf_rd_en;
    end
  end

  assign busy      = (state_q != SEQ_IDLE);
  assign buf_addr  = addr_q;
  assign out_valid = outv_q;
endmodule

// File: rtl/bxc_host_xfer.sv
`timescale 1ns/1ps
module bxc_host_xfer #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 16,
  parameter int NREGS  = 16,
  parameter int PACE   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              buf_rd_en,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              irq
);
  localparam int IDX_W = $clog2(NREGS);

  logic              rst_sync_n;
  logic [IDX_W-1:0]  idx_q;
  logic              idx_load, idx_step, data_wr;
  logic              irq_en_q, out_off_q, flag_q;
  logic              start_pulse, ack_pulse;
  logic [ADDR_W-1:0] start_addr_q;
  logic [CNT_W-1:0]  count_q;
  logic [DATA_W-1:0] reg_rd;
  logic              busy, done;

  assign idx_load = host_wr && !host_sel;
  assign idx_step = host_sel && (host_wr || host_rd);
  assign data_wr  = host_sel && host_wr;

  bxc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bxc_index_ptr #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_sync_n), .load(idx_load),
    .load_val(host_wdata[IDX_W-1:0]), .step(idx_step), .idx_q(idx_q)
  );

  bxc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .data_wr(data_wr), .idx(idx_q),
    .wdata(host_wdata), .busy(busy), .cnt_dec(buf_rd_en), .done(done),
    .irq_en_q(irq_en_q), .out_off_q(out_off_q), .start_addr_q(start_addr_q),
    .count_q(count_q), .flag_q(flag_q), .start_pulse(start_pulse),
    .ack_pulse(ack_pulse), .rd_data(reg_rd)
  );

  bxc_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PACE(PACE)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start_pulse(start_pulse),
    .out_en(!out_off_q), .start_addr(start_addr_q), .count(count_q),
    .busy(busy), .buf_rd_en(buf_rd_en), .buf_addr(buf_addr),
    .done(done), .out_valid(out_valid)
  );

  assign host_rdata = host_sel ? reg_rd : DATA_W'(idx_q);
  assign out_data   = out_valid ? buf_rdata : '0;
  assign irq        = flag_q && irq_en_q;
endmodule

// File: rtl/bxc_checker.sv
`timescale 1ns/1ps
module bxc_checker #(
  parameter int IDX_W = 4,
  parameter int PACE  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_sel,
  input logic             host_wr,
  input logic             host_rd,
  input logic [IDX_W-1:0] host_idx_in,
  input logic [IDX_W-1:0] idx,
  input logic             busy,
  input logic             flag,
  input logic             ack,
  input logic             done,
  input logic             buf_rd_en,
  input logic             out_valid
);
  logic [7:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (buf_rd_en) begin
      gap_q  <= 8'd1;
      seen_q <= 1'b1;
    end else begin
      if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
      if (!busy) seen_q <= 1'b0;
    end
  end

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_sel && host_wr) |=> (idx == $past(host_idx_in))); // R2
  AST_IDX_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && (host_wr || host_rd) && idx == '0) |=> (idx == '0)); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && (host_wr || host_rd) && idx != '0) |=> (idx == $past(idx) + 1'b1)); // R3
  AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |-> busy); // R6
  AST_READ_PACE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd_en && seen_q) |-> (gap_q == 8'(PACE))); // R7
  AST_OUT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(buf_rd_en)); // R7
  AST_FLAG_FROM_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(busy)); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !done) |=> !flag); // R11
endmodule

bind bxc_host_xfer bxc_checker #(.IDX_W(IDX_W), .PACE(PACE)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .host_idx_in(host_wdata[IDX_W-1:0]), .idx(idx_q),
  .busy(busy), .flag(flag_q), .ack(ack_pulse), .done(done),
  .buf_rd_en(buf_rd_en), .out_valid(out_valid)
);

// File: tb/test_bxc_host_xfer.sv
`timescale 1ns/1ps
module test_bxc_host_xfer;
  logic       clk;
  logic       rst_n;
  logic       host_sel, host_wr, host_rd;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       buf_rd_en;
  logic [15:0] buf_addr;
  logic [7:0] buf_rdata;
  logic       out_valid;
  logic [7:0] out_data;
  logic       irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int cap_n  = 0;
  logic [7:0] cap_data [0:63];
  int         cap_cyc  [0:63];
  bit         finished = 0;

  bxc_host_xfer i_bxc_host_xfer (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .buf_rd_en(buf_rd_en), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .out_valid(out_valid), .out_data(out_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) if (buf_rd_en) buf_rdata <= pat(buf_addr);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (out_valid) begin
      if (cap_n < 64) begin
        cap_data[cap_n] <= out_data;
        cap_cyc[cap_n]  <= cyc;
      end
      cap_n <= cap_n + 1;
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] idx, output logic [7:0] d);
    wr(1'b0, {4'h0, idx});
    rd(1'b1, d);
  endtask

  task automatic launch(input logic [7:0] ctrl, input logic [11:0] cnt,
                        input logic [15:0] addr, output int base);
    wr(1'b0, 8'd1);
    wr(1'b1, ctrl);
    wr(1'b1, cnt[7:0]);
    wr(1'b1, {4'h0, cnt[11:8]});
    wr(1'b1, addr[7:0]);
    wr(1'b1, addr[15:8]);
    base = cap_n;
    wr(1'b1, 8'h3C);
  endtask

  task automatic check_stream(input int base, input int nbytes,
                              input logic [15:0] addr, input string tag);
    chk(cap_n - base, nbytes, {tag, " byte count"});
    for (int i = 0; i < nbytes; i++) begin
      chk(cap_data[base + i], pat(addr + 16'(i)), $sformatf("%s byte %0d", tag, i));
      if (i > 0) chk(cap_cyc[base + i] - cap_cyc[base + i - 1], 7, $sformatf("R7 gap %0d", i));
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk(irq, 0, "R1 irq at reset");
    chk(out_valid, 0, "R1 out_valid at reset");
    rd_reg(4'd1, d); chk(d, 8'hFF, "R1 status at reset");
    rd(1'b1, d);     chk(d, 8'h00, "R1 count low at reset");
    rd(1'b1, d);     chk(d, 8'h00, "R1 count high at reset");
    rd(1'b0, d);     chk(d, 8'h04, "R3 index after two steps");
  endtask

  task automatic t_index;
    logic [7:0] d;
    wr(1'b0, 8'hF9); rd(1'b0, d); chk(d, 8'h09, "R2 index load low nibble");
    wr(1'b0, 8'd2); wr(1'b1, 8'h34); wr(1'b1, 8'h01);
    rd_reg(4'd2, d); chk(d, 8'h34, "R4 count low via auto step");
    rd(1'b1, d);     chk(d, 8'h01, "R4 count high nibble");
    wr(1'b0, 8'd0); wr(1'b1, 8'h11); wr(1'b1, 8'h22); rd(1'b1, d);
    rd(1'b0, d); chk(d, 8'h00, "R3 index 0 sticky");
    wr(1'b0, 8'd15); wr(1'b1, 8'h00);
    rd(1'b0, d); chk(d, 8'h00, "R3 wrap 15 to 0");
    wr(1'b0, 8'd14); rd(1'b1, d); rd(1'b0, d); chk(d, 8'h0F, "R3 step 14 to 15");
  endtask

  task automatic t_basic;
    int base;
    logic [7:0] d;
    launch(8'h40, 12'd3, 16'h1234, base);
    rd_reg(4'd1, d); chk(d & 8'h48, 8'h40, "R9 busy shown during transfer");
    repeat (40) @(negedge clk);
    check_stream(base, 4, 16'h1234, "R5 R6 basic");
    rd_reg(4'd2, d); chk(d, 8'hFF, "R8 count low after end");
    rd(1'b1, d);     chk(d, 8'h8F, "R8 R4 count high and flag");
    rd_reg(4'd1, d); chk(d, 8'hBF, "R9 status after end");
    chk(irq, 1, "R10 irq enabled");
    wr(1'b0, 8'd7); wr(1'b1, 8'hFF);
    #1 chk(irq, 0, "R11 ack clears irq");
    rd_reg(4'd3, d); chk(d[7], 0, "R11 flag cleared");
  endtask

  task automatic t_mask;
    int base;
    logic [7:0] d;
    launch(8'h00, 12'd0, 16'h0080, base);
    repeat (15) @(negedge clk);
    check_stream(base, 1, 16'h0080, "R6 single byte");
    chk(irq, 0, "R10 irq masked");
    rd_reg(4'd3, d); chk(d[7], 1, "R10 flag set while masked");
    wr(1'b0, 8'd1); wr(1'b1, 8'h40);
    #1 chk(irq, 1, "R10 irq after enable");
    wr(1'b0, 8'd7); wr(1'b1, 8'h00);
    #1 chk(irq, 0, "R11 ack with zero data");
  endtask

  task automatic t_busy_ignore;
    int base;
    logic [7:0] d;
    launch(8'h40, 12'd5, 16'h0200, base);
    wr(1'b0, 8'd6); wr(1'b1, 8'h00);
    wr(1'b0, 8'd2); wr(1'b1, 8'h00); wr(1'b1, 8'h00);
    repeat (50) @(negedge clk);
    check_stream(base, 6, 16'h0200, "R6 R4 busy ignore");
    rd_reg(4'd2, d); chk(d, 8'hFF, "R8 count after ignored writes");
    wr(1'b0, 8'd7); wr(1'b1, 8'h5A);
  endtask

  task automatic t_disabled;
    int base;
    logic [7:0] d;
    launch(8'h42, 12'd2, 16'h0300, base);
    repeat (30) @(negedge clk);
    chk(cap_n - base, 0, "R6 no bytes with output disabled");
    rd_reg(4'd1, d); chk(d, 8'hFF, "R6 R9 idle after blocked start");
  endtask

  task automatic t_wrap;
    int base;
    launch(8'h40, 12'd3, 16'hFFFE, base);
    repeat (40) @(negedge clk);
    check_stream(base, 4, 16'hFFFE, "R5 address wrap");
    chk(irq, 1, "R10 irq after wrap run");
    wr(1'b0, 8'd7); wr(1'b1, 8'h00);
  endtask

  initial begin
    host_sel = 0; host_wr = 0; host_rd = 0; host_wdata = 0; buf_rdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_index;
    t_basic;
    t_mask;
    t_busy_ignore;
    t_disabled;
    t_wrap;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule